// File: doc/BRIEF.md
# Byte-Compare Terminated String Loader

This block copies a run of bytes from a byte-wide memory port into a register file, four bytes to a register. The first byte lands in the top lane (bits 31:24) of the starting register. Each following byte moves one lane down. After the bottom lane, loading continues in the top lane of the next register, and the register index wraps from the last register back to 0. Each byte is written with a single-lane byte enable, so the other lanes of the target register keep whatever they held before.

The run ends early when a byte equal to a supplied compare value has been handled. Otherwise it ends after the requested number of bytes. Two register indices are protected and never receive a write. The first of them is protected only when it is nonzero. A byte aimed at a protected register is still read and still counted. When the run finishes, a one-cycle done pulse carries the number of bytes processed. For an early stop this number is the zero-based position of the matching byte.

The address advances by one per byte. In narrow mode the address sum is truncated to 32 bits, so it wraps at the 32-bit boundary and the upper bits read as zero.

Top module: `bsl_strload`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. Accepting it captures every command input. A start that arrives while `busy` is high is ignored and has no effect on the run in progress.
- R2: Each byte is fetched by one handshake. `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_ack` is high, and `mem_rdata` is taken in that cycle. `mem_req` and `rf_we` are never high in the same cycle.
- R3: The first read address is `base_addr`, and each later read address is the previous one plus 1. When `narrow` is 1, the next address is the low 32 bits of that sum, zero-extended.
- R4: Byte k (counting from 0) goes to lane k mod 4, where lane 0 is bits 31:24 (`rf_be`=1000) and lane 3 is bits 7:0 (`rf_be`=0001). Its register index is `start_reg` plus floor(k/4), modulo 32.
- R5: On every write, exactly one `rf_be` bit is set and `rf_wdata` holds the loaded byte copied into all four lanes. Only the enabled lane is written.
- R6: No write is issued when the target index equals `prot_b`.
- R7: No write is issued when `prot_a` is nonzero and the target index equals `prot_a`. When `prot_a` is 0, register 0 is written normally.
- R8: A byte whose write is suppressed is still read and still counts toward the result.
- R9: After the byte at position k equals `cmp_byte`, no further reads are made, and `result` is k.
- R10: If no byte matches, exactly `byte_cnt` bytes are read and `result` equals `byte_cnt`.
- R11: A `byte_cnt` of 0 makes no memory request. It gives `done` in the cycle after the start, with `result` 0.
- R12: `done` is high for exactly one cycle, and `result` is valid while `done` is high. For a nonzero count, `done` comes one cycle after the write-strobe cycle of the last byte. After reset, `busy`, `done`, `mem_req` and `rf_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| base_addr | input | ADDR_W | Address of the first byte |
| narrow | input | 1 | 1 = address sums wrap at 32 bits |
| byte_cnt | input | CNT_W | Maximum number of bytes to load |
| cmp_byte | input | 8 | Terminating byte value |
| start_reg | input | 5 | First destination register |
| prot_a | input | 5 | Protected index, active only when nonzero |
| prot_b | input | 5 | Protected index, always active |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 8 | Read byte |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 5 | Write register index |
| rf_be | output | 4 | Lane enable, bit 3 = bits 31:24 |
| rf_wdata | output | 32 | Loaded byte copied into all lanes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | CNT_W | Bytes processed, valid with done |

## Verification
The start edge loads the command, and `mem_req` rises in the next cycle. The clock edge that samples `mem_ack` is followed by one cycle of `rf_we`, or of a suppressed write, and the cycle after that carries `done` if the byte was the last one. A zero count gives `done` one cycle after the start edge. The reference model in the bench turns each observed acknowledge into an expected write exactly one cycle later and an expected `done` one cycle after that. It then checks `rf_we`, `done` and `mem_req` against those expectations on every falling edge, so an event that comes early, comes late or is missing shows up as a miscompare.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WR   = 2'd2
    } bsl_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       hit;
    } bsl_byte_t;

    function automatic logic [3:0] lane_enable(input logic [1:0] lane);
        return 4'b1000 >> lane;
    endfunction

endpackage

// File: rtl/bsl_guard.sv
module bsl_guard #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] target,
    input  logic [REG_W-1:0] prot_a,
    input  logic [REG_W-1:0] prot_b,
    output logic             blocked
);
    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_b   = (target == prot_b);
        hit_a   = (prot_a != '0) && (target == prot_a);
        blocked = hit_a | hit_b;
    end
endmodule

// File: rtl/bsl_cursor.sv
module bsl_cursor #(
    parameter int ADDR_W   = 64,
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              narrow,
    input  logic [ADDR_W-1:0] base,
    input  logic [REG_W-1:0]  first_reg,
    output logic [ADDR_W-1:0] addr,
    output logic [REG_W-1:0]  reg_idx,
    output logic [1:0]        lane
);
    localparam logic [REG_W-1:0] LAST_REG = REG_W'(NUM_REGS - 1);

    logic [ADDR_W-1:0] addr_sum;
    logic [ADDR_W-1:0] addr_next;

    assign addr_sum = addr + ADDR_W'(1);

    generate
        if (ADDR_W > 32) begin : g_wide
            always_comb begin
                addr_next = addr_sum;
                if (narrow) begin
                    addr_next = {{(ADDR_W-32){1'b0}}, addr_sum[31:0]};
                end
            end
        end else begin : g_flat
            always_comb addr_next = addr_sum;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            reg_idx <= '0;
            lane    <= '0;
        end else if (load) begin
            addr    <= base;
            reg_idx <= first_reg;
            lane    <= '0;
        end else if (step) begin
            addr <= addr_next;
            lane <= lane + 2'd1;
            if (lane == 2'd3) begin
                reg_idx <= (reg_idx == LAST_REG) ? '0 : reg_idx + REG_W'(1);
            end
        end
    end
endmodule

// File: rtl/bsl_strload.sv
module bsl_strload
    import bsl_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 8,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              narrow,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [7:0]        cmp_byte,
    input  logic [REG_W-1:0]  start_reg,
    input  logic [REG_W-1:0]  prot_a,
    input  logic [REG_W-1:0]  prot_b,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_idx,
    output logic [3:0]        rf_be,
    output logic [31:0]       rf_wdata,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  result
);
    bsl_state_e       state;
    bsl_byte_t        cur;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos_q;
    logic [7:0]       cmp_q;
    logic [REG_W-1:0] pa_q;
    logic [REG_W-1:0] pb_q;
    logic             narrow_q;
    logic             done_q;
    logic [CNT_W-1:0] result_q;

    logic             accept;
    logic             load;
    logic             step;
    logic             last_byte;
    logic             blocked;
    logic [REG_W-1:0] cur_reg;
    logic [1:0]       cur_lane;

    assign accept    = start && (state == ST_IDLE);
    assign load      = accept && (byte_cnt != '0);
    assign last_byte = (pos_q == cnt_q - CNT_W'(1));
    assign step      = (state == ST_WR) && !cur.hit && !last_byte;

    bsl_cursor #(
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS),
        .REG_W   (REG_W)
    ) u_cursor (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .narrow   (narrow_q),
        .base     (base_addr),
        .first_reg(start_reg),
        .addr     (mem_addr),
        .reg_idx  (cur_reg),
        .lane     (cur_lane)
    );

    bsl_guard #(
        .REG_W(REG_W)
    ) u_guard (
        .target (cur_reg),
        .prot_a (pa_q),
        .prot_b (pb_q),
        .blocked(blocked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '0;
            cnt_q    <= '0;
            pos_q    <= '0;
            cmp_q    <= '0;
            pa_q     <= '0;
            pb_q     <= '0;
            narrow_q <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cnt_q    <= byte_cnt;
                        cmp_q    <= cmp_byte;
                        pa_q     <= prot_a;
                        pb_q     <= prot_b;
                        narrow_q <= narrow;
                        pos_q    <= '0;
                        if (byte_cnt == '0) begin
                            done_q   <= 1'b1;
                            result_q <= '0;
                        end else begin
                            state <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_ack) begin
                        cur.data <= mem_rdata;
                        cur.hit  <= (mem_rdata == cmp_q);
                        state    <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (cur.hit || last_byte) begin
                        done_q   <= 1'b1;
                        result_q <= cur.hit ? pos_q : cnt_q;
                        state    <= ST_IDLE;
                    end else begin
                        pos_q <= pos_q + CNT_W'(1);
                        state <= ST_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state == ST_REQ);
        rf_we    = (state == ST_WR) && !blocked;
        rf_idx   = cur_reg;
        rf_be    = lane_enable(cur_lane);
        rf_wdata = {4{cur.data}};
        busy     = (state != ST_IDLE);
        done     = done_q;
        result   = result_q;
    end
endmodule

// File: rtl/bsl_strload_chk.sv
module bsl_strload_chk #(
    parameter int ADDR_W = 64,
    parameter int REG_W  = 5,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic [REG_W-1:0]  prot_a,
    input logic [REG_W-1:0]  prot_b,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_we,
    input logic [REG_W-1:0]  rf_idx,
    input logic [3:0]        rf_be,
    input logic              done,
    input logic [CNT_W-1:0]  result
);
    logic [CNT_W-1:0] cnt_c;
    logic [REG_W-1:0] pa_c;
    logic [REG_W-1:0] pb_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_c <= '0;
            pa_c  <= '0;
            pb_c  <= '0;
        end else if (start && !busy) begin
            cnt_c <= byte_cnt;
            pa_c  <= prot_a;
            pb_c  <= prot_b;
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2
    req_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && rf_we));

    // R5
    lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> ($countones(rf_be) == 1));

    // R6
    prot_b_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_idx != pb_c));

    // R7
    prot_a_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we && (pa_c != '0)) |-> (rf_idx != pa_c));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    result_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (result <= cnt_c));
endmodule

bind bsl_strload bsl_strload_chk #(
    .ADDR_W(ADDR_W),
    .REG_W (REG_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .byte_cnt(byte_cnt),
    .prot_a  (prot_a),
    .prot_b  (prot_b),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .rf_we   (rf_we),
    .rf_idx  (rf_idx),
    .rf_be   (rf_be),
    .done    (done),
    .result  (result)
);

// File: tb/bsl_strload_test.sv
module bsl_strload_test;
    localparam int AW = 64;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          narrow = 1'b0;
    logic [CW-1:0] byte_cnt = '0;
    logic [7:0]    cmp_byte = '0;
    logic [4:0]    start_reg = '0;
    logic [4:0]    prot_a = '0;
    logic [4:0]    prot_b = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic          rf_we;
    logic [4:0]    rf_idx;
    logic [3:0]    rf_be;
    logic [31:0]   rf_wdata;
    logic          busy;
    logic          done;
    logic [CW-1:0] result;

    bsl_strload #(.ADDR_W(AW), .NUM_REGS(32), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .narrow(narrow), .byte_cnt(byte_cnt), .cmp_byte(cmp_byte),
        .start_reg(start_reg), .prot_a(prot_a), .prot_b(prot_b),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_be(rf_be), .rf_wdata(rf_wdata), .busy(busy), .done(done),
        .result(result)
    );

    always #4 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // reference model state
    logic [AW-1:0] q_addr[$];
    bit            q_we[$];
    logic [4:0]    q_idx[$];
    logic [3:0]    q_be[$];
    logic [7:0]    q_byte[$];
    bit            q_last[$];
    int            exp_res = 0;
    bit            mbusy = 0;
    bit            done_due = 0;
    bit            wr_due = 0;
    bit            cur_we, cur_last;
    logic [4:0]    cur_idx;
    logic [3:0]    cur_be;
    logic [7:0]    cur_byte;
    int            wait_cnt = 0;
    logic [7:0]    lfsr = 8'h5B;

    function automatic logic [7:0] mem_fn(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[39:32] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic build_expect();
        logic [AW-1:0] a = base_addr;
        int            r = start_reg;
        int            ln = 0;
        int            n = byte_cnt;
        logic [7:0]    b;
        exp_res = n;
        for (int i = 0; i < n; i++) begin
            b = mem_fn(a);
            q_addr.push_back(a);
            q_we.push_back(!((5'(r) == prot_b) || (prot_a != 0 && 5'(r) == prot_a)));
            q_idx.push_back(5'(r));
            q_be.push_back(4'b1000 >> ln);
            q_byte.push_back(b);
            if (b == cmp_byte) begin
                exp_res = i;
                q_last.push_back(1'b1);
                break;
            end
            q_last.push_back(i == n - 1);
            a  = narrow ? {32'h0, a[31:0] + 32'd1} : a + 64'd1;
            ln = (ln + 1) % 4;
            if (ln == 0) r = (r + 1) % 32;
        end
        if (n == 0) done_due = 1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst && start && !mbusy) begin
            mbusy = 1;
            build_expect();
        end
    end

    always @(negedge clk) begin
        bit next_done;
        if (!rst) begin
            next_done = 0;
            chk(done === done_due, "R12 done timing", 64'(done), 64'(done_due));
            if (done_due) begin
                chk(result == CW'(exp_res), "R9 R10 R11 result", 64'(result), 64'(exp_res));
                mbusy = 0;
            end
            if (wr_due) begin
                chk(rf_we === cur_we, "R6 R7 R8 write strobe", 64'(rf_we), 64'(cur_we));
                if (cur_we) begin
                    chk(rf_idx == cur_idx, "R4 register index", 64'(rf_idx), 64'(cur_idx));
                    chk(rf_be == cur_be, "R4 lane enable", 64'(rf_be), 64'(cur_be));
                    chk(rf_wdata == {4{cur_byte}}, "R5 write data", 64'(rf_wdata),
                        64'({4{cur_byte}}));
                end
                if (cur_last) next_done = 1;
            end else if (rf_we) begin
                chk(1'b0, "R9 R10 unexpected write", 64'(rf_we), 64'd0);
            end
            wr_due = 0;
            mem_ack = 1'b0;
            if (mem_req) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R2 R9 R11 unexpected request", 64'(mem_req), 64'd0);
                end else if (wait_cnt == 0) begin
                    chk(mem_addr == q_addr[0], "R3 read address", mem_addr, q_addr[0]);
                    void'(q_addr.pop_front());
                    cur_we   = q_we.pop_front();
                    cur_idx  = q_idx.pop_front();
                    cur_be   = q_be.pop_front();
                    cur_byte = q_byte.pop_front();
                    cur_last = q_last.pop_front();
                    wr_due   = 1;
                    mem_ack  = 1'b1;
                    mem_rdata = mem_fn(mem_addr);
                    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    wait_cnt = int'(lfsr % 3);
                end else begin
                    wait_cnt--;
                end
            end
            done_due = next_done;
        end
    end

    task automatic run(input logic [AW-1:0] ba, input bit nw, input int cnt,
                       input logic [7:0] cb, input int sr, input int pa, input int pb);
        @(negedge clk); #1;
        base_addr = ba; narrow = nw; byte_cnt = CW'(cnt); cmp_byte = cb;
        start_reg = 5'(sr); prot_a = 5'(pa); prot_b = 5'(pb); start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        while (mbusy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req == 0 && rf_we == 0,
            "R12 reset state", {busy, done, mem_req, rf_we}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        // R4 R10: plain load, compare byte chosen far outside the data
        run(64'h100, 0, 7, 8'hFF, 3, 0, 20);
        // R9: stop on the byte at position 5
        run(64'h240, 0, 12, mem_fn(64'h245), 1, 0, 31);
        // R9: match on the very first byte gives result 0
        run(64'h380, 0, 6, mem_fn(64'h380), 7, 0, 31);
        // R6 R8: prot_b inside the range
        run(64'h400, 0, 9, 8'hFF, 10, 0, 11);
        // R7: nonzero prot_a inside the range
        run(64'h500, 0, 9, 8'hFF, 12, 12, 31);
        // R7: prot_a of zero leaves register 0 writable
        run(64'h600, 0, 5, 8'hFF, 0, 0, 31);
        // R4: register index wraps from 31 to 0
        run(64'h700, 0, 12, 8'hFF, 30, 0, 5);
        // R3: narrow mode wraps at 32 bits, wide mode carries
        run(64'h0000_0005_FFFF_FFFE, 1, 5, 8'hFF, 2, 0, 31);
        run(64'h0000_0005_FFFF_FFFE, 0, 5, 8'hFF, 2, 0, 31);
        // R11: zero count
        run(64'h800, 0, 0, 8'h00, 4, 0, 31);
        // R1: a second start while busy is ignored
        @(negedge clk); #1;
        base_addr = 64'h900; narrow = 0; byte_cnt = 8; cmp_byte = 8'hFF;
        start_reg = 6; prot_a = 0; prot_b = 31; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        @(negedge clk); #1;
        chk(busy == 1'b1, "R1 busy during run", 64'(busy), 64'd1);
        base_addr = 64'hA00; byte_cnt = 3; start_reg = 20; prot_b = 6; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        while (mbusy) @(negedge clk);
        @(negedge clk);
        // mixed patterns
        for (int k = 0; k < 20; k++) begin
            run(64'(k * 97 + 64'h1_0000), k[0], (k * 7) % 40 + 1,
                mem_fn(64'(k * 97 + 64'h1_0000 + (k % 9))), (k * 5) % 32,
                (k * 3) % 32, (k * 11 + 1) % 32);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        while (cycles < 150000) @(posedge clk);
        chk(1'b0, "R12 watchdog expired", 64'(cycles), 64'd0);
        finish_run();
    end
endmodule